// File: doc/BRIEF.md
# Oscillator Period Capture Timer

This block is a 16-bit up-counter that measures the period of a slow, asynchronous clock against its own known time base. In capture mode, each rising edge of the measured clock copies the running count into the timer's reload register. Software can read two successive capture values and subtract them. A built-in helper register already holds that difference, with wrap-around handled.

The measured clock passes through a multi-flop synchronizer. Only a rising edge seen in the timer clock domain causes a capture. Outside capture mode the block is a plain auto-reload timer: on overflow the counter loads the reload value. In capture mode the counter runs freely through each capture and wraps to zero. Software reaches every register through a byte-wide bus. It reads and writes the counter and reload halves, and it controls the run and mode bits and the two sticky flags.

Top module: `osc_period_timer`

## Requirements
- R1: After reset, the counter, reload, difference and control registers read 0, and both flags are low.
- R2: The measured clock is synchronized through SYNC_STAGES flops (default 2). A capture happens only on its rising edge while capture mode (control bit 1) is set. Edges while capture mode is clear change no register.
- R3: On a capture, the full 16-bit count is copied into the reload register, with both bytes in the same cycle.
- R4: On a capture, the difference register takes (new capture − previous reload) modulo 2^16. Two edges of the measured clock N timer cycles apart give a difference of N.
- R5: In capture mode, a running counter at 0xFFFF goes to 0x0000 and never loads the reload value.
- R6: With capture mode clear, a running counter at 0xFFFF loads the reload value.
- R7: The overflow flag (control bit 3) is set on every wrap of a running counter, in both modes. Writing 0 to that bit clears it; writing 1 leaves it unchanged.
- R8: The capture flag (control bit 2) is set on every capture. Writing 0 to that bit clears it; writing 1 leaves it unchanged.
- R9: Register addresses are: 0 count low, 1 count high, 2 reload low, 3 reload high, 4 control, 5 difference low, 6 difference high. rd_data shows the register at addr one clock after addr is presented.
- R10: The counter advances once per clock only while run (control bit 0) is 1. A write to a count byte takes effect in place of that cycle's increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock (known time base) |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for both read and write |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Registered read data |
| meas_clk | input | 1 | Asynchronous clock being measured |
| cap_flag | output | 1 | Sticky capture flag |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The hardest situation to produce is an exact, known spacing between two captures while the counter is running, because synchronizer latency moves every capture. The bench raises the measured clock at the same clock phase for both pulses, placed a fixed number of cycles apart. The latency then cancels, and the difference register must equal that spacing. Absolute capture values are checked with the counter stopped and preloaded, so the captured value does not depend on the synchronizer delay.

// File: rtl/optimer_pkg.sv
package optimer_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CNT_LO = 3'd0,
    A_CNT_HI = 3'd1,
    A_RLD_LO = 3'd2,
    A_RLD_HI = 3'd3,
    A_CTRL   = 3'd4,
    A_DIF_LO = 3'd5,
    A_DIF_HI = 3'd6
  } reg_addr_e;

  localparam int B_RUN   = 0;
  localparam int B_CAPEN = 1;
  localparam int B_CAPF  = 2;
  localparam int B_OVF   = 3;
endpackage

// File: rtl/optimer_edge.sv
module optimer_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise_o
);
  logic [STAGES-1:0] sr;
  logic              last;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr   <= '0;
      last <= 1'b0;
    end else begin
      sr   <= {sr[STAGES-2:0], async_in};
      last <= sr[STAGES-1];
    end
  end

  assign rise_o = sr[STAGES-1] & ~last;

  // R2: a detected edge lasts exactly one timer cycle
  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o);
endmodule

// File: rtl/optimer_count.sv
module optimer_count #(
  parameter int BW = 8,
  localparam int W = 2*BW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          cap_mode,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [BW-1:0] wdata,
  input  logic [W-1:0]  reload,
  output logic [W-1:0]  cnt,
  output logic          wrap_o
);
  logic any_wr;
  assign any_wr = wr_lo | wr_hi;
  assign wrap_o = run & (&cnt) & ~any_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (any_wr) begin
      if (wr_lo) cnt[BW-1:0] <= wdata;
      if (wr_hi) cnt[W-1:BW] <= wdata;
    end else if (run) begin
      if (&cnt) cnt <= cap_mode ? '0 : reload;
      else      cnt <= cnt + 1'b1;
    end
  end

  assert_wrap_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (run && cap_mode && (&cnt) && !any_wr) |=> (cnt == '0));
  assert_wrap_reload_R6: assert property (@(posedge clk) disable iff (rst)
    (run && !cap_mode && (&cnt) && !any_wr) |=> (cnt == $past(reload)));
  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!run && !any_wr) |=> $stable(cnt));
endmodule

// File: rtl/optimer_capt.sv
module optimer_capt #(
  parameter int BW      = 8,
  parameter bit DIFF_EN = 1'b1,
  localparam int W = 2*BW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap_evt,
  input  logic [W-1:0]  cnt,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [BW-1:0] wdata,
  output logic [W-1:0]  reload,
  output logic [W-1:0]  diff
);
  always_ff @(posedge clk) begin
    if (rst) begin
      reload <= '0;
    end else if (cap_evt) begin
      reload <= cnt;
    end else begin
      if (wr_lo) reload[BW-1:0] <= wdata;
      if (wr_hi) reload[W-1:BW] <= wdata;
    end
  end

  generate
    if (DIFF_EN) begin : g_diff
      logic [W-1:0] diff_q;
      always_ff @(posedge clk) begin
        if (rst)          diff_q <= '0;
        else if (cap_evt) diff_q <= cnt - reload;
      end
      assign diff = diff_q;

      assert_diff_R4: assert property (@(posedge clk) disable iff (rst)
        cap_evt |=> (diff == W'($past(cnt) - $past(reload))));
    end else begin : g_nodiff
      assign diff = '0;
    end
  endgenerate

  assert_capture_copy_R3: assert property (@(posedge clk) disable iff (rst)
    cap_evt |=> (reload == $past(cnt)));
endmodule

// File: rtl/osc_period_timer.sv
module osc_period_timer
  import optimer_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter bit DIFF_EN     = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] rd_data,
  input  logic              meas_clk,
  output logic              cap_flag,
  output logic              ovf_flag
);
  localparam int CNT_W = 2*BYTE_W;

  logic run_q, capen_q;
  logic rise, cap_evt, wrap;
  logic [CNT_W-1:0] cnt, reload, diff;
  logic wr_clo, wr_chi, wr_rlo, wr_rhi, wr_ctl;

  assign wr_clo = wr_en && (addr == A_CNT_LO);
  assign wr_chi = wr_en && (addr == A_CNT_HI);
  assign wr_rlo = wr_en && (addr == A_RLD_LO);
  assign wr_rhi = wr_en && (addr == A_RLD_HI);
  assign wr_ctl = wr_en && (addr == A_CTRL);

  optimer_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .async_in(meas_clk), .rise_o(rise)
  );

  assign cap_evt = rise & capen_q;

  optimer_count #(.BW(BYTE_W)) u_cnt (
    .clk(clk), .rst(rst), .run(run_q), .cap_mode(capen_q),
    .wr_lo(wr_clo), .wr_hi(wr_chi), .wdata(wr_data),
    .reload(reload), .cnt(cnt), .wrap_o(wrap)
  );

  optimer_capt #(.BW(BYTE_W), .DIFF_EN(DIFF_EN)) u_cap (
    .clk(clk), .rst(rst), .cap_evt(cap_evt), .cnt(cnt),
    .wr_lo(wr_rlo), .wr_hi(wr_rhi), .wdata(wr_data),
    .reload(reload), .diff(diff)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q    <= 1'b0;
      capen_q  <= 1'b0;
      cap_flag <= 1'b0;
      ovf_flag <= 1'b0;
    end else begin
      if (wr_ctl) begin
        run_q   <= wr_data[B_RUN];
        capen_q <= wr_data[B_CAPEN];
      end
      if (cap_evt)     cap_flag <= 1'b1;
      else if (wr_ctl) cap_flag <= cap_flag & wr_data[B_CAPF];
      if (wrap)        ovf_flag <= 1'b1;
      else if (wr_ctl) ovf_flag <= ovf_flag & wr_data[B_OVF];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (addr)
        A_CNT_LO: rd_data <= cnt[BYTE_W-1:0];
        A_CNT_HI: rd_data <= cnt[CNT_W-1:BYTE_W];
        A_RLD_LO: rd_data <= reload[BYTE_W-1:0];
        A_RLD_HI: rd_data <= reload[CNT_W-1:BYTE_W];
        A_CTRL: begin
          rd_data         <= '0;
          rd_data[B_RUN]  <= run_q;
          rd_data[B_CAPEN] <= capen_q;
          rd_data[B_CAPF] <= cap_flag;
          rd_data[B_OVF]  <= ovf_flag;
        end
        A_DIF_LO: rd_data <= diff[BYTE_W-1:0];
        A_DIF_HI: rd_data <= diff[CNT_W-1:BYTE_W];
        default:  rd_data <= '0;
      endcase
    end
  end

  assert_capflag_set_R8: assert property (@(posedge clk) disable iff (rst)
    cap_evt |=> cap_flag);
  assert_ovfflag_set_R7: assert property (@(posedge clk) disable iff (rst)
    wrap |=> ovf_flag);
  assert_capflag_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_ctl && !wr_data[B_CAPF] && !cap_evt) |=> !cap_flag);
  assert_no_capture_off_R2: assert property (@(posedge clk) disable iff (rst)
    (!capen_q && !wr_rlo && !wr_rhi) |=> $stable(reload));
endmodule

// File: tb/tb_osc_period_timer.sv
module tb_osc_period_timer;
  logic       clk = 1'b0;
  logic       rst;
  logic       wr_en;
  logic [2:0] addr;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic       meas_clk;
  logic       cap_flag;
  logic       ovf_flag;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  osc_period_timer dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .meas_clk(meas_clk), .cap_flag(cap_flag), .ovf_flag(ovf_flag)
  );

  localparam int NV = 6;
  localparam logic [15:0] VEC [NV] = '{16'h0000, 16'h1234, 16'hFFFF,
                                       16'h0001, 16'h8000, 16'h7FFF};

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a;
    @(posedge clk);
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic rd16(input logic [2:0] lo_a, output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(lo_a, lo);
    rd(lo_a + 3'd1, hi);
    v = {hi, lo};
  endtask

  task automatic pulse();
    @(negedge clk);
    meas_clk = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    meas_clk = 1'b0;
    repeat (4) @(posedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] w, prev;
    rst = 1'b1; wr_en = 1'b0; addr = '0; wr_data = '0; meas_clk = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1 reset state, R9 addresses
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), b);
      chk("R1 reset read", {8'h00, b}, 16'h0000);
    end
    chk("R1 cap_flag", {15'd0, cap_flag}, 16'd0);
    chk("R1 ovf_flag", {15'd0, ovf_flag}, 16'd0);

    // Vector table: stopped counter preloaded, one capture each (R3 R4 R8 R9 R10)
    prev = 16'h0000;
    for (int i = 0; i < NV; i++) begin
      wr(3'd4, 8'h02);
      wr(3'd0, VEC[i][7:0]);
      wr(3'd1, VEC[i][15:8]);
      pulse();
      rd16(3'd2, w);
      chk("R3 capture value", w, VEC[i]);
      rd16(3'd5, w);
      chk("R4 capture difference", w, VEC[i] - prev);
      rd(3'd4, b);
      chk("R8 capture flag set", {8'h00, b}, 16'h0006);
      rd16(3'd0, w);
      chk("R10 stopped counter holds", w, VEC[i]);
      prev = VEC[i];
    end

    // R8: writing 1 keeps the flag, writing 0 clears it
    wr(3'd4, 8'h06);
    rd(3'd4, b);
    chk("R8 write 1 keeps", {8'h00, b}, 16'h0006);
    wr(3'd4, 8'h02);
    rd(3'd4, b);
    chk("R8 write 0 clears", {8'h00, b}, 16'h0002);

    // R2: edge ignored with capture mode clear
    wr(3'd4, 8'h00);
    wr(3'd0, 8'h55);
    wr(3'd1, 8'h55);
    pulse();
    rd16(3'd2, w);
    chk("R2 edge ignored reload", w, 16'h7FFF);
    rd(3'd4, b);
    chk("R2 edge ignored flag", {8'h00, b}, 16'h0000);

    // R5 + R7: capture mode wrap to zero
    wr(3'd2, 8'h34);
    wr(3'd3, 8'h12);
    wr(3'd0, 8'hFE);
    wr(3'd1, 8'hFF);
    wr(3'd4, 8'h03);
    repeat (3) @(posedge clk);
    wr(3'd4, 8'h0A);
    rd16(3'd0, w);
    chk("R5 wrap to zero", w, 16'h0002);
    rd(3'd4, b);
    chk("R7 overflow flag set", {8'h00, b}, 16'h000A);
    wr(3'd4, 8'h02);
    rd(3'd4, b);
    chk("R7 overflow flag clear", {8'h00, b}, 16'h0002);

    // R6 + R7: timer mode reload on overflow
    wr(3'd0, 8'hFE);
    wr(3'd1, 8'hFF);
    wr(3'd4, 8'h01);
    repeat (3) @(posedge clk);
    wr(3'd4, 8'h08);
    rd16(3'd0, w);
    chk("R6 reload on overflow", w, 16'h1236);
    rd(3'd4, b);
    chk("R7 overflow flag timer mode", {8'h00, b}, 16'h0008);

    // R4: running counter, two edges 40 cycles apart
    wr(3'd4, 8'h03);
    pulse();
    repeat (32) @(posedge clk);
    pulse();
    wr(3'd4, 8'h00);
    rd16(3'd5, w);
    chk("R4 period of 40 cycles", w, 16'd40);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule